// File: doc/BRIEF.md
# Reduced-Wordlength Booth Multiplier

This block multiplies two 16-bit signed operands and returns the full 32-bit signed product. Before the operands reach the partial-product array, a reduction front end can lower the effective precision of either operand. It has two ways to do this. Truncation clears the N low-order bits. Signed right shift moves the operand N places toward the LSB and fills the vacated top bits with copies of the sign bit.

The multiplier uses radix-4 modified Booth recoding on one operand only. The other operand is used as it stands. A swap input chooses which operand is recoded, so a system can put the operand whose activity matters more on the cheaper side of the array. Each row is formed as a one's complement with a correction bit added at the row's LSB. Sign extension is handled by a single precomputed constant rather than by replicated sign bits.

There is one register stage. The block takes a sample, with its reduction and swap settings, on each clock edge where `in_valid` is high. The product appears one cycle later. A two-state controller marks whether the output holds a fresh result:
- `ST_IDLE` is the reset state and holds no fresh result.
- `ST_RESULT` holds a fresh result.
- The transition *accept* goes from either state to `ST_RESULT` when `in_valid` is high.
- The transition *drain* goes from either state to `ST_IDLE` when `in_valid` is low.

Top module: `rwl_booth_mul`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted sample, `prod` is 0 and `out_valid` is 0.
- R2: `out_valid` is high in exactly the cycle after an edge where `in_valid` was high, and low after an edge where `in_valid` was low.
- R3: The product is the exact 32-bit two's-complement product of the two reduced operands, including the case -32768 × -32768 = 2^30.
- R4: With `red_mode` = 0 (truncation), each selected operand has its N least significant bits forced to zero and keeps its upper 16-N bits.
- R5: With `red_mode` = 1 (signed shift), each selected operand is arithmetically shifted right by N, and the sign is copied into the top N bits.
- R6: `red_sel` bit 0 applies the reduction to `op_a` and bit 1 applies it to `op_b`. An operand whose bit is 0 passes through unchanged, and N = 0 leaves both operands unchanged.
- R7: With `swap` = 0, `op_b` is Booth-recoded and `op_a` is not. With `swap` = 1 the roles are exchanged. The product is the same either way.
- R8: While `in_valid` is low, `prod` holds its last value, and changes to the operands, `red_mode`, `red_amt`, `red_sel` and `swap` have no effect until the next accepted sample.
- R9: Every value of `red_amt` from 0 to 15 is accepted. Truncation by 8 gives effective precisions of 8 bits, and the unreduced path gives 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| op_a | input | 16 | Signed operand A |
| op_b | input | 16 | Signed operand B |
| red_mode | input | 1 | Reduction kind: 0 truncation, 1 signed right shift |
| red_amt | input | 4 | Reduction amount N (0..15) |
| red_sel | input | 2 | Operands to reduce: bit 0 A, bit 1 B |
| swap | input | 1 | 0: recode B; 1: recode A |
| prod | output | 32 | Registered signed product |
| out_valid | output | 1 | Product is fresh this cycle |

## Verification
The properties assume that `in_valid` and all settings are held at known values whenever reset is released. They also assume that the inputs change only away from the rising edge, because the product check compares the output with a model fed from the values sampled at the accepting edge. The bench drives every input on the falling edge and keeps `in_valid` low throughout reset. It then walks every reduction amount, both modes, all four operand selections and both swap settings over a fixed set of corner operands, which includes the most negative value. Between accepted samples it scrambles the settings to confirm that nothing leaks through.

// File: rtl/rwl_pkg.sv
package rwl_pkg;
    typedef enum logic {
        RED_TRUNC = 1'b0,
        RED_SHIFT = 1'b1
    } red_mode_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

    // one Booth digit: magnitude one, magnitude two, negate
    typedef struct packed {
        logic one;
        logic two;
        logic neg;
    } booth_dig_t;
endpackage

// File: rtl/wl_reduce.sv
module wl_reduce #(
    parameter int W  = 16,
    parameter int NW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic          en,
    input  logic          mode,
    input  logic [NW-1:0] amt,
    output logic [W-1:0]  dout
);
    import rwl_pkg::*;

    always_comb begin
        if (!en) begin
            dout = din;
        end else if (red_mode_e'(mode) == RED_TRUNC) begin
            dout = din & ({W{1'b1}} << amt);
        end else begin
            dout = W'($signed(din) >>> amt);
        end
    end
endmodule

// File: rtl/booth_enc.sv
module booth_enc #(
    parameter int W    = 16,
    parameter int NDIG = W / 2
) (
    input  logic [W-1:0]                       y,
    output rwl_pkg::booth_dig_t [NDIG-1:0]     dig
);
    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [2:0] grp;
        if (i == 0) begin : g_first
            assign grp = {y[1], y[0], 1'b0};
        end else begin : g_rest
            assign grp = {y[2*i+1], y[2*i], y[2*i-1]};
        end
        assign dig[i].one = grp[1] ^ grp[0];
        assign dig[i].two = (grp[2] & ~grp[1] & ~grp[0]) | (~grp[2] & grp[1] & grp[0]);
        assign dig[i].neg = grp[2] & ~(grp[1] & grp[0]);
    end
endmodule

// File: rtl/pp_sum.sv
module pp_sum #(
    parameter int W    = 16,
    parameter int NDIG = W / 2,
    parameter int PW   = 2 * W
) (
    input  logic [W-1:0]                   x,
    input  rwl_pkg::booth_dig_t [NDIG-1:0] dig,
    output logic [PW-1:0]                  sum
);
    // Subtract 2^(W+2i) per row: sign-encoding constant.
    function automatic logic [PW-1:0] sign_const();
        logic [PW-1:0] acc;
        acc = '0;
        for (int i = 0; i < NDIG; i++) begin
            acc = acc - (PW'(1) << (W + 2 * i));
        end
        return acc;
    endfunction

    localparam logic [PW-1:0] KSIGN = sign_const();

    logic [W:0]    xs;
    logic [W:0]    x2;
    logic [PW-1:0] row_w [NDIG];

    assign xs = {x[W-1], x};
    assign x2 = {x, 1'b0};

    for (genvar i = 0; i < NDIG; i++) begin : g_row
        logic [W:0] mag;
        logic [W:0] row;
        always_comb begin
            if (dig[i].one)      mag = xs;
            else if (dig[i].two) mag = x2;
            else                 mag = '0;
        end
        assign row = mag ^ {(W+1){dig[i].neg}};
        // flip row sign bit, place at weight 2i, add correction bit
        assign row_w[i] = (PW'({~row[W], row[W-1:0]}) << (2 * i))
                        + (PW'(dig[i].neg) << (2 * i));
    end

    always_comb begin
        sum = KSIGN;
        for (int i = 0; i < NDIG; i++) begin
            sum = sum + row_w[i];
        end
    end
endmodule

// File: rtl/rwl_booth_mul.sv
module rwl_booth_mul #(
    parameter int W  = 16,
    parameter int NW = $clog2(W),
    parameter int PW = 2 * W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  op_a,
    input  logic [W-1:0]  op_b,
    input  logic          red_mode,
    input  logic [NW-1:0] red_amt,
    input  logic [1:0]    red_sel,
    input  logic          swap,
    output logic [PW-1:0] prod,
    output logic          out_valid
);
    import rwl_pkg::*;

    localparam int NDIG = W / 2;

    logic [W-1:0]  a_red;
    logic [W-1:0]  b_red;
    logic [W-1:0]  rec_op;
    logic [W-1:0]  plain_op;
    logic [PW-1:0] sum;
    booth_dig_t [NDIG-1:0] dig;
    ctl_state_e    state;
    ctl_state_e    nxt;
    logic [PW-1:0] prod_q;

    wl_reduce #(.W(W), .NW(NW)) i_red_a (
        .din(op_a), .en(red_sel[0]), .mode(red_mode), .amt(red_amt), .dout(a_red)
    );
    wl_reduce #(.W(W), .NW(NW)) i_red_b (
        .din(op_b), .en(red_sel[1]), .mode(red_mode), .amt(red_amt), .dout(b_red)
    );

    assign rec_op   = swap ? a_red : b_red;
    assign plain_op = swap ? b_red : a_red;

    booth_enc #(.W(W), .NDIG(NDIG)) i_enc (
        .y(rec_op), .dig(dig)
    );

    pp_sum #(.W(W), .NDIG(NDIG), .PW(PW)) i_sum (
        .x(plain_op), .dig(dig), .sum(sum)
    );

    always_comb begin
        unique case (state)
            ST_IDLE:   nxt = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: nxt = in_valid ? ST_RESULT : ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        prod_q <= '0;
        else if (in_valid) prod_q <= sum;
    end

    assign prod      = prod_q;
    assign out_valid = (state == ST_RESULT);
endmodule

// File: rtl/rwl_booth_mul_chk.sv
module rwl_booth_mul_chk #(
    parameter int W  = 16,
    parameter int NW = $clog2(W),
    parameter int PW = 2 * W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  op_a,
    input logic [W-1:0]  op_b,
    input logic          red_mode,
    input logic [NW-1:0] red_amt,
    input logic [1:0]    red_sel,
    input logic          swap,
    input logic [PW-1:0] prod,
    input logic          out_valid
);
    function automatic logic signed [W-1:0] model_red(logic [W-1:0] v, logic en,
                                                      logic m, logic [NW-1:0] n);
        if (!en)     return v;
        else if (!m) return v & ({W{1'b1}} << n);
        else         return $signed(v) >>> n;
    endfunction

    logic signed [W-1:0]  ma;
    logic signed [W-1:0]  mb;
    logic signed [PW-1:0] model_prod;

    assign ma = model_red(op_a, red_sel[0], red_mode, red_amt);
    assign mb = model_red(op_b, red_sel[1], red_mode, red_amt);
    assign model_prod = PW'(ma) * PW'(mb);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    product_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> prod == $past(model_prod));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(prod));

    // R4
    trunc_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !red_mode && red_sel[0] && red_amt == NW'(W / 2))
        |=> prod[W/2-1:0] == '0);

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && $past(!rst_n) |-> prod == '0);
endmodule

bind rwl_booth_mul rwl_booth_mul_chk #(.W(W), .NW(NW), .PW(PW)) i_chk (.*);

// File: tb/test_rwl_booth_mul.sv
module test_rwl_booth_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        red_mode = 1'b0;
    logic [3:0]  red_amt = '0;
    logic [1:0]  red_sel = '0;
    logic        swap = 1'b0;
    logic [31:0] prod;
    logic        out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    rwl_booth_mul i_rwl_booth_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .red_mode(red_mode), .red_amt(red_amt), .red_sel(red_sel), .swap(swap),
        .prod(prod), .out_valid(out_valid)
    );

    function automatic logic signed [15:0] ref_red(logic [15:0] v, bit en, bit m, int n);
        if (!en) return v;
        if (!m)  return v & (16'hFFFF << n);
        return $signed(v) >>> n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one accepted sample, checked on the following falling edge
    task automatic run_op(string req, logic [15:0] a, logic [15:0] b, bit m,
                          int n, logic [1:0] sel, bit sw);
        logic signed [15:0] ra;
        logic signed [15:0] rb;
        logic signed [31:0] e;
        ra = ref_red(a, sel[0], m, n);
        rb = ref_red(b, sel[1], m, n);
        e  = ra * rb;
        @(negedge clk);
        op_a = a; op_b = b; red_mode = m; red_amt = 4'(n); red_sel = sel; swap = sw;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, prod, e);
        check("R2", 32'(out_valid), 32'd1);
    endtask

    logic [15:0] vals [10];

    initial begin
        logic [31:0] held;
        logic [15:0] lcg;
        vals[0] = 16'h8000; vals[1] = 16'h7FFF; vals[2] = 16'hFFFF; vals[3] = 16'h0000;
        vals[4] = 16'h0001; vals[5] = 16'h5555; vals[6] = 16'hAAAA;
        lcg = 16'hACE1;
        for (int k = 7; k < 10; k++) begin
            lcg = lcg * 16'd25173 + 16'd13849;
            vals[k] = lcg;
        end

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", prod, 32'd0);
        check("R1", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", prod, 32'd0);
        check("R2", 32'(out_valid), 32'd0);

        // R3: most negative squared, both recode choices (R7)
        run_op("R3", 16'h8000, 16'h8000, 1'b0, 0, 2'b00, 1'b0);
        run_op("R7", 16'h8000, 16'h8000, 1'b0, 0, 2'b00, 1'b1);
        check("R3", prod, 32'h4000_0000);

        // R9: sweep every N, both modes, all selections, both swaps
        for (int n = 0; n < 16; n++) begin
            for (int m = 0; m < 2; m++) begin
                for (int sel = 0; sel < 4; sel++) begin
                    for (int sw = 0; sw < 2; sw++) begin
                        for (int k = 0; k < 10; k++) begin
                            string tag;
                            if (sel == 0 || n == 0) tag = "R6";
                            else if (sw == 1)       tag = "R7";
                            else if (m == 0)        tag = "R4";
                            else                    tag = "R5";
                            run_op(tag, vals[k], vals[(k * 3 + 1) % 10], m[0], n,
                                   2'(sel), sw[0]);
                        end
                    end
                end
            end
        end

        // R9: truncation to 8 effective bits on both operands
        run_op("R9", 16'h7FFF, 16'h8000, 1'b0, 8, 2'b11, 1'b0);
        check("R9", prod, 32'hC080_0000);

        // R5: shift of most negative by 15 gives -1 on both
        run_op("R5", 16'h8000, 16'h8000, 1'b1, 15, 2'b11, 1'b1);
        check("R5", prod, 32'd1);

        // R8: settings and operands change while idle; output must hold
        run_op("R8", 16'h1234, 16'hF00D, 1'b1, 3, 2'b01, 1'b0);
        held = prod;
        @(negedge clk);
        op_a = 16'h8000; op_b = 16'h7FFF; red_mode = 1'b0; red_amt = 4'd15;
        red_sel = 2'b11; swap = 1'b1;
        @(negedge clk);
        check("R8", prod, held);
        check("R2", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R8", prod, held);
        // next accepted sample uses the new settings
        run_op("R8", 16'h8000, 16'h7FFF, 1'b0, 15, 2'b11, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule